// File: doc/BRIEF.md
# Flat Level-Sensitive Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into a single interrupt line for a processor core. Each source has its own enable bit, and a global enable bit gates the whole block. The interrupt line is raised whenever the global enable is set and at least one request is high while its enable bit is also set. The block has no hardware priority and no vectors. Every interrupt goes to one common handler, and that handler reads a registered pending vector to choose which source to service.

Software writes the enable mask and the status word through a simple write port. A one-bit select chooses which of the two is written. On exception entry the core pulses an entry strobe. This copies the global enable into a saved field and clears the global enable. A return strobe copies the saved value back into the global enable. A handler can therefore set the global enable again to allow nested interrupts, after first keeping the saved field in software.

Top module: `irqc_flat`

## Requirements
- R1: After reset the enable mask, the global enable, the saved enable and the pending vector are all zero, and `irq_o` is low.
- R2: `irq_o` is high exactly when `gie_o` is 1 and some source n has `req_i[n]` = 1 and enable bit n = 1. It follows `req_i` in the same cycle, with no register on that path.
- R3: A write with `cr_sel_i` = 0 loads `cr_wdata_i[NSRC-1:0]` into the enable mask, with bit n enabling source n. The new mask governs `irq_o` from the cycle after the write edge.
- R4: `pend_o` equals `req_i & mask`, captured at each clock edge. It therefore lags the inputs by one cycle, and it does not depend on the global enable.
- R5: Requests are not latched. When a request drops, `irq_o` loses it in the same cycle and `pend_o` loses it one cycle later.
- R6: A write with `cr_sel_i` = 1 sets the global enable from `cr_wdata_i[0]` and the saved enable from `cr_wdata_i[1]`. All other data bits are ignored.
- R7: An `exc_entry_i` pulse copies the global enable into the saved enable and clears the global enable at that edge. It takes precedence over a return strobe or a status write in the same cycle.
- R8: An `exc_ret_i` pulse without an entry strobe copies the saved enable into the global enable and leaves the saved enable unchanged. It takes precedence over a status write in the same cycle.
- R9: Nesting works as follows. If the handler sets the global enable again, a second entry saves 1 and clears the global enable, and the matching return restores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC (32) | Level-sensitive request lines |
| cr_wr_i | input | 1 | Control write strobe |
| cr_sel_i | input | 1 | Write target: 0 selects the enable mask, 1 selects the status word |
| cr_wdata_i | input | DATA_W (32) | Write data |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_ret_i | input | 1 | Exception return strobe |
| irq_o | output | 1 | Interrupt to the core |
| pend_o | output | NSRC (32) | Registered pending vector (requests AND mask) |
| gie_o | output | 1 | Global interrupt enable |
| gie_saved_o | output | 1 | Saved global enable |

## Verification
Some properties are checked by assertions on every cycle:
- `irq_o` is never high while the global enable is clear or while no request is high.
- A pending bit never appears for a source that was not requesting at the previous edge.
- An entry always clears the global enable and saves its prior value.
- A lone return restores the saved value.
- A mask write lands at the next edge.

Other behaviour only the bench's scenarios can show. This covers the exact timing of a mask change on the interrupt line, the precedence between entry, return and status writes in the same cycle, the way status writes ignore the upper data bits, and a full nested entry and return sequence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic {
      CR_SEL_MASK = 1'b0,
      CR_SEL_STAT = 1'b1
   } cr_sel_e;

   localparam int unsigned STAT_GIE_BIT = 0;
   localparam int unsigned STAT_SAV_BIT = 1;
   localparam int unsigned STAT_USED_W  = 2;

endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NSRC-1:0]   mask_o
);

   localparam int unsigned SPARE_W = DATA_W - NSRC;

   initial begin
      if (NSRC == 0 || NSRC > DATA_W)
         $error("irqc_mask_reg: NSRC must be in 1..DATA_W");
   end

   logic [NSRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_i)
         mask_q <= wdata_i[NSRC-1:0];
   end

   generate
      if (SPARE_W > 0) begin : g_spare
         logic spare_unused;
         assign spare_unused = ^wdata_i[DATA_W-1:NSRC];
      end
   endgenerate

   assign mask_o = mask_q;

endmodule

// File: rtl/irqc_status_ctl.sv
module irqc_status_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic wgie_i,
   input  logic wsav_i,
   input  logic entry_i,
   input  logic ret_i,
   output logic gie_o,
   output logic sav_o
);

   logic gie_q, sav_q;
   logic gie_d, sav_d;

   always_comb begin
      gie_d = gie_q;
      sav_d = sav_q;
      if (entry_i) begin
         sav_d = gie_q;
         gie_d = 1'b0;
      end else if (ret_i) begin
         gie_d = sav_q;
      end else if (wr_i) begin
         gie_d = wgie_i;
         sav_d = wsav_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         sav_q <= 1'b0;
      end else begin
         gie_q <= gie_d;
         sav_q <= sav_d;
      end
   end

   assign gie_o = gie_q;
   assign sav_o = sav_q;

endmodule

// File: rtl/irqc_pend_stage.sv
module irqc_pend_stage #(
   parameter int unsigned NSRC     = 32,
   parameter bit          PEND_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic            gie_i,
   output logic            irq_o,
   output logic [NSRC-1:0] pend_o
);

   logic [NSRC-1:0] live;

   generate
      for (genvar n = 0; n < NSRC; n++) begin : g_src
         assign live[n] = req_i[n] & mask_i[n];
      end

      if (PEND_REG) begin : g_reg
         logic [NSRC-1:0] pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q <= '0;
            else
               pend_q <= live;
         end
         assign pend_o = pend_q;
      end else begin : g_comb
         logic clk_unused;
         assign clk_unused = clk ^ rst_n;
         assign pend_o = live;
      end
   endgenerate

   assign irq_o = gie_i & (|live);

endmodule

// File: rtl/irqc_flat.sv
module irqc_flat
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          PEND_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_i,
   input  logic              cr_wr_i,
   input  logic              cr_sel_i,
   input  logic [DATA_W-1:0] cr_wdata_i,
   input  logic              exc_entry_i,
   input  logic              exc_ret_i,
   output logic              irq_o,
   output logic [NSRC-1:0]   pend_o,
   output logic              gie_o,
   output logic              gie_saved_o
);

   initial begin
      if (DATA_W < STAT_USED_W)
         $error("irqc_flat: DATA_W too narrow for status word");
      if (NSRC == 0 || NSRC > DATA_W)
         $error("irqc_flat: NSRC must be in 1..DATA_W");
   end

   cr_sel_e         sel;
   logic            wr_mask, wr_stat;
   logic [NSRC-1:0] en_mask;
   logic            gie, sav;

   assign sel     = cr_sel_e'(cr_sel_i);
   assign wr_mask = cr_wr_i && (sel == CR_SEL_MASK);
   assign wr_stat = cr_wr_i && (sel == CR_SEL_STAT);

   irqc_mask_reg #(
      .NSRC   (NSRC),
      .DATA_W (DATA_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_mask),
      .wdata_i (cr_wdata_i),
      .mask_o  (en_mask)
   );

   irqc_status_ctl u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_stat),
      .wgie_i  (cr_wdata_i[STAT_GIE_BIT]),
      .wsav_i  (cr_wdata_i[STAT_SAV_BIT]),
      .entry_i (exc_entry_i),
      .ret_i   (exc_ret_i),
      .gie_o   (gie),
      .sav_o   (sav)
   );

   irqc_pend_stage #(
      .NSRC     (NSRC),
      .PEND_REG (PEND_REG)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .mask_i (en_mask),
      .gie_i  (gie),
      .irq_o  (irq_o),
      .pend_o (pend_o)
   );

   assign gie_o       = gie;
   assign gie_saved_o = sav;

endmodule

// File: rtl/irqc_flat_chk.sv
module irqc_flat_chk #(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   req_i,
   input logic              cr_wr_i,
   input logic              cr_sel_i,
   input logic [DATA_W-1:0] cr_wdata_i,
   input logic              exc_entry_i,
   input logic              exc_ret_i,
   input logic              irq_o,
   input logic [NSRC-1:0]   pend_o,
   input logic              gie_o,
   input logic              gie_saved_o,
   input logic [NSRC-1:0]   en_mask
);

   assert_irq_needs_gie_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_o);

   assert_irq_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> !irq_o);

   assert_pend_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_o & ~$past(req_i)) == '0));

   assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_wr_i && !cr_sel_i) |=> (en_mask == $past(cr_wdata_i[NSRC-1:0])));

   assert_entry_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry_i |=> !gie_o);

   assert_entry_saves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry_i |=> (gie_saved_o == $past(gie_o)));

   assert_ret_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ret_i && !exc_entry_i) |=> (gie_o == $past(gie_saved_o)) && $stable(gie_saved_o));

endmodule

bind irqc_flat irqc_flat_chk #(
   .NSRC   (NSRC),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .cr_wr_i     (cr_wr_i),
   .cr_sel_i    (cr_sel_i),
   .cr_wdata_i  (cr_wdata_i),
   .exc_entry_i (exc_entry_i),
   .exc_ret_i   (exc_ret_i),
   .irq_o       (irq_o),
   .pend_o      (pend_o),
   .gie_o       (gie_o),
   .gie_saved_o (gie_saved_o),
   .en_mask     (en_mask)
);

// File: tb/irqc_flat_tb.sv
`timescale 1ns/1ps
module irqc_flat_tb;

   localparam int unsigned NSRC = 32;
   localparam int unsigned DW   = 32;

   typedef struct {
      string           tag;
      logic            irq;
      logic [NSRC-1:0] pend;
      logic            gie;
      logic            sav;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] req = '0;
   logic            wr = 1'b0;
   logic            sel = 1'b0;
   logic [DW-1:0]   wdata = '0;
   logic            ent = 1'b0;
   logic            ret = 1'b0;
   logic            irq;
   logic [NSRC-1:0] pend;
   logic            gie, sav;

   int checks = 0;
   int fails  = 0;
   exp_t sb[$];

   logic [NSRC-1:0] m_mask = '0;
   logic [NSRC-1:0] m_pend = '0;
   logic            m_gie  = 1'b0;
   logic            m_sav  = 1'b0;

   always #2 clk = ~clk;

   irqc_flat u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .cr_wr_i     (wr),
      .cr_sel_i    (sel),
      .cr_wdata_i  (wdata),
      .exc_entry_i (ent),
      .exc_ret_i   (ret),
      .irq_o       (irq),
      .pend_o      (pend),
      .gie_o       (gie),
      .gie_saved_o (sav)
   );

   // Drive one cycle at the falling edge, queue what must be seen before the next rising edge,
   // then advance the reference state across that edge.
   task automatic cyc(input string tag, input logic [NSRC-1:0] r, input logic w,
                      input logic s, input logic [DW-1:0] d, input logic e, input logic rt);
      exp_t x;
      @(negedge clk);
      req = r; wr = w; sel = s; wdata = d; ent = e; ret = rt;
      x.tag  = tag;
      x.irq  = m_gie && ((r & m_mask) != '0);
      x.pend = m_pend;
      x.gie  = m_gie;
      x.sav  = m_sav;
      sb.push_back(x);
      m_pend = r & m_mask;
      if (w && !s) m_mask = d[NSRC-1:0];
      if (e) begin
         m_sav = m_gie;
         m_gie = 1'b0;
      end else if (rt) begin
         m_gie = m_sav;
      end else if (w && s) begin
         m_gie = d[0];
         m_sav = d[1];
      end
   endtask

   // Monitor: one rising-edge-minus-1ns sample per queued item.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() != 0) begin
            exp_t x;
            x = sb.pop_front();
            checks++;
            if (irq !== x.irq || pend !== x.pend || gie !== x.gie || sav !== x.sav) begin
               fails++;
               $display("FAIL %s: irq=%b pend=%h gie=%b sav=%b expected irq=%b pend=%h gie=%b sav=%b",
                        x.tag, irq, pend, gie, sav, x.irq, x.pend, x.gie, x.sav);
            end
         end
      end
   end

   initial begin
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      checks++;
      if (irq !== 1'b0 || pend !== '0 || gie !== 1'b0 || sav !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: irq=%b pend=%h gie=%b sav=%b expected all zero", irq, pend, gie, sav);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R2: all requests high, mask and global enable still zero
      cyc("R1 mask zero after reset", '1, 0, 0, '0, 0, 0);
      // R3: write mask bit 4; irq still gated by gie=0 (R2)
      cyc("R3 mask write, gie off", 32'h10, 1, 0, 32'h0000_0010, 0, 0);
      cyc("R4 pend with gie off", 32'h10, 0, 0, '0, 0, 0);
      // R6: status write sets gie (bit0)
      cyc("R6 status write gie=1", 32'h10, 1, 1, 32'h1, 0, 0);
      cyc("R2 enabled source raises irq", 32'h10, 0, 0, '0, 0, 0);
      cyc("R2 unmasked source only", 32'h20, 0, 0, '0, 0, 0);
      cyc("R5 request dropped", 32'h0, 0, 0, '0, 0, 0);
      cyc("R5 pend cleared", 32'h0, 0, 0, '0, 0, 0);
      // R3: mask change, checked in the write cycle and the cycle after
      cyc("R3 write mask bit5 with req5", 32'h20, 1, 0, 32'h0000_0020, 0, 0);
      cyc("R3 new mask live next cycle", 32'h20, 0, 0, '0, 0, 0);
      cyc("R3 old source now masked", 32'h10, 0, 0, '0, 0, 0);
      cyc("R3 full mask write", 32'h8000_0001, 1, 0, 32'hFFFF_FFFF, 0, 0);
      cyc("R2 top and bottom sources", 32'h8000_0001, 0, 0, '0, 0, 0);
      // R6: upper bits ignored, bits 0/1 clear
      cyc("R6 status write ignores upper bits", 32'h1, 1, 1, 32'hFFFF_FFFC, 0, 0);
      cyc("R6 gie cleared blocks irq", 32'h1, 0, 0, '0, 0, 0);
      cyc("R6 write saved=1 gie=0", 32'h1, 1, 1, 32'h2, 0, 0);
      cyc("R6 saved field set", 32'h1, 1, 1, 32'h3, 0, 0);
      // R7: entry wins over simultaneous status write
      cyc("R7 entry with status write", 32'h1, 1, 1, 32'h1, 1, 0);
      cyc("R7 after entry gie clear saved set", 32'h1, 0, 0, '0, 0, 0);
      // R8: return restores, wins over status write
      cyc("R8 return with status write", 32'h1, 1, 1, 32'h0, 0, 1);
      cyc("R8 gie restored", 32'h1, 0, 0, '0, 0, 0);
      // R7: entry beats return in the same cycle
      cyc("R7 entry and return together", 32'h1, 0, 0, '0, 1, 1);
      cyc("R7 entry won", 32'h1, 0, 0, '0, 0, 0);
      cyc("R8 return restores 1", 32'h1, 0, 0, '0, 0, 1);
      // R9: nested sequence
      cyc("R9 outer entry", 32'h1, 0, 0, '0, 1, 0);
      cyc("R9 handler re-enables", 32'h0, 1, 1, 32'h1, 0, 0);
      cyc("R9 nested irq visible", 32'h4, 0, 0, '0, 0, 0);
      cyc("R9 inner entry", 32'h4, 0, 0, '0, 1, 0);
      cyc("R9 inside inner handler", 32'h0, 0, 0, '0, 0, 0);
      cyc("R9 inner return", 32'h0, 0, 0, '0, 0, 1);
      cyc("R9 after inner return", 32'h0, 0, 0, '0, 0, 0);
      cyc("R8 return keeps saved", 32'h0, 0, 0, '0, 0, 1);
      cyc("R4 pend alternating pattern", 32'hA5A5_5A5A, 0, 0, '0, 0, 0);
      cyc("R4 pend second pattern", 32'h0F0F_F0F0, 1, 0, 32'h00FF_00FF, 0, 0);
      cyc("R4 pend masked pattern", 32'hFFFF_FFFF, 0, 0, '0, 0, 0);
      cyc("R4 pend drain", 32'h0, 0, 0, '0, 0, 0);

      @(negedge clk);
      req = '0; wr = 0; ent = 0; ret = 0;
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule